// File: doc/BRIEF.md
# Burst-Count Event Link

This block carries events from one synchronous domain to another over a request/acknowledge handshake, and one handshake moves a whole batch of events. On the sending side, every cycle with `load_evt` high adds one event to a pending counter. When a handshake starts, the whole pending count goes onto `burst_bus` and the counter clears. On the receiving side, the count is added to a backlog counter. The backlog is then handed to the local logic one event at a time, through `new_evt` and `release_evt`.

The handshake runs in 4-phase or 2-phase form, chosen by `two_phase`. Two strobes model the wire delay. `strobe_fwd` lets the receiver observe the current request level. `strobe_back` lets the transmitter observe the current acknowledge level.

Transmitter states:
- `TX_IDLE`: no handshake is running.
- `TX_WAIT_ACK_HI` and `TX_WAIT_ACK_LO`: the two waits of a 4-phase handshake.
- `TX_WAIT_TOGGLE`: the single wait of a 2-phase handshake.

Transmitter transitions:
- Start: `TX_IDLE` goes to a wait state when pending plus the current load is nonzero.
- Ack-rise: `TX_WAIT_ACK_HI` goes to `TX_WAIT_ACK_LO`, and the request drops.
- Ack-fall: `TX_WAIT_ACK_LO` goes to `TX_IDLE`.
- Ack-match: `TX_WAIT_TOGGLE` goes to `TX_IDLE`.

Receiver states:
- `RX_LISTEN` and `RX_HOLD`.

Receiver transitions:
- Req-rise: `RX_LISTEN` goes to `RX_HOLD`, and the acknowledge rises.
- Req-fall: `RX_HOLD` goes to `RX_LISTEN`, the count is added, and the acknowledge falls.
- In 2-phase mode, `RX_LISTEN` adds the count and copies the request level onto the acknowledge on every request change.

Delivery states and transitions:
- Offer: `DLV_EMPTY` goes to `DLV_OFFER` when the backlog is nonzero, taking one event.
- Retire: `DLV_OFFER` goes to `DLV_EMPTY` when `release_evt` is high.

Top module: `burst_link`

## Requirements
- R1: After reset, all of `new_evt`, `req_line`, `ack_line`, `tx_busy`, `pending_cnt` and `backlog_cnt` are 0.
- R2: A load seen while the transmitter is idle with nothing pending starts a handshake at that clock edge. `burst_bus` then reads 1 and `tx_busy` is 1. `req_line` rises in 4-phase mode and inverts in 2-phase mode.
- R3: Loads seen during a handshake build up in `pending_cnt`. When the transmitter next becomes idle, it starts a new handshake. That handshake drives the full pending count on `burst_bus` and clears `pending_cnt`. `burst_bus` holds its value while `tx_busy` is 1.
- R4: `pending_cnt` saturates at 2^TXC_W-1.
- R5: The acknowledge does not change while the receiver has not been given `strobe_fwd`.
- R6: In 4-phase mode (`two_phase`=0), a request rise seen by the receiver adds nothing to `backlog_cnt`. The count is added only when the receiver sees the request fall.
- R7: In 2-phase mode (`two_phase`=1), the count is added on the first request change the receiver sees. The acknowledge then takes the request level.
- R8: Until the acknowledge return is observed through `strobe_back`, the transmitter stays busy and keeps events pending. The return is the acknowledge fall in 4-phase mode, or the matching acknowledge level in 2-phase mode.
- R9: When `new_evt` is 0 and `backlog_cnt` is nonzero, on the next cycle `new_evt` is 1 and `backlog_cnt` is one lower.
- R10: While `new_evt` is 1, `backlog_cnt` is not decremented. A cycle with `release_evt` high makes `new_evt` 0 on the next cycle.
- R11: The number of `new_evt` offers equals the number of events loaded, as long as no counter saturates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| two_phase | input | 1 | Handshake form: 0 selects 4-phase, 1 selects 2-phase; held during operation |
| load_evt | input | 1 | One event loaded per high cycle |
| strobe_fwd | input | 1 | Lets the receiver sample the request line |
| strobe_back | input | 1 | Lets the transmitter sample the acknowledge line |
| release_evt | input | 1 | Local logic has taken the offered event |
| new_evt | output | 1 | One event on offer to the receiving logic |
| pending_cnt | output | TXC_W | Events waiting in the transmitter |
| burst_bus | output | TXC_W | Count carried by the current handshake |
| backlog_cnt | output | RXC_W | Events received but not yet offered |
| req_line | output | 1 | Request wire |
| ack_line | output | 1 | Acknowledge wire |
| tx_busy | output | 1 | A handshake is in progress |

## Verification
The checker assumes that `two_phase` changes only while reset is held. It also assumes that the total number of events in flight stays below the receiver's maximum, so the offer-count relation holds without saturation. The directed tasks set the mode before they release reset, keep every batch small except the one case aimed at transmitter saturation, and pulse each strobe for a single cycle followed by idle cycles. Each handshake step therefore settles before the next stimulus arrives.

// File: rtl/burst_link_pkg.sv
package burst_link_pkg;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_WAIT_ACK_HI,
        TX_WAIT_ACK_LO,
        TX_WAIT_TOGGLE
    } tx_state_e;

    typedef enum logic {
        RX_LISTEN,
        RX_HOLD
    } rx_state_e;

    typedef enum logic {
        DLV_EMPTY,
        DLV_OFFER
    } dlv_state_e;

endpackage

// File: rtl/burst_link_tx.sv
module burst_link_tx
    import burst_link_pkg::*;
#(
    parameter int TXC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             two_phase,
    input  logic             load_evt,
    input  logic             strobe_back,
    input  logic             ack_line,
    output logic             req_line,
    output logic [TXC_W-1:0] burst_bus,
    output logic [TXC_W-1:0] pending_cnt,
    output logic             tx_busy
);

    localparam logic [TXC_W-1:0] CNT_MAX = '1;
    localparam logic [TXC_W-1:0] CNT_ONE = TXC_W'(1);

    tx_state_e        state_q, state_d;
    logic [TXC_W-1:0] cnt_q, cnt_inc, bus_q;
    logic             req_q, ack_seen_q, start;

    // pending count including this cycle's load, clamped at the top
    always_comb begin
        cnt_inc = cnt_q;
        if (load_evt && cnt_q != CNT_MAX)
            cnt_inc = cnt_q + CNT_ONE;
    end

    assign start = (state_q == TX_IDLE) && (cnt_inc != '0);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:        if (start) state_d = two_phase ? TX_WAIT_TOGGLE : TX_WAIT_ACK_HI;
            TX_WAIT_ACK_HI: if (ack_seen_q) state_d = TX_WAIT_ACK_LO;
            TX_WAIT_ACK_LO: if (!ack_seen_q) state_d = TX_IDLE;
            TX_WAIT_TOGGLE: if (ack_seen_q == req_q) state_d = TX_IDLE;
            default:        state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            bus_q      <= '0;
            req_q      <= 1'b0;
            ack_seen_q <= 1'b0;
        end else begin
            if (strobe_back) ack_seen_q <= ack_line;
            if (start) begin
                bus_q <= cnt_inc;
                cnt_q <= '0;
                req_q <= two_phase ? ~req_q : 1'b1;
            end else begin
                cnt_q <= cnt_inc;
                if (state_q == TX_WAIT_ACK_HI && ack_seen_q)
                    req_q <= 1'b0;
            end
        end
    end

    assign req_line    = req_q;
    assign burst_bus   = bus_q;
    assign pending_cnt = cnt_q;
    assign tx_busy     = (state_q != TX_IDLE);

endmodule

// File: rtl/burst_link_rx.sv
module burst_link_rx
    import burst_link_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic two_phase,
    input  logic strobe_fwd,
    input  logic req_line,
    output logic ack_line,
    output logic fwd_seen,
    output logic add_en
);

    rx_state_e state_q, state_d;
    logic      seen_q, ack_q;

    always_comb begin
        state_d = state_q;
        add_en  = 1'b0;
        unique case (state_q)
            RX_LISTEN: begin
                if (two_phase) begin
                    if (seen_q != ack_q) add_en = 1'b1;
                end else if (seen_q) begin
                    state_d = RX_HOLD;
                end
            end
            RX_HOLD: begin
                if (!seen_q) begin
                    add_en  = 1'b1;
                    state_d = RX_LISTEN;
                end
            end
            default: state_d = RX_LISTEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RX_LISTEN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            ack_q  <= 1'b0;
        end else begin
            if (strobe_fwd) seen_q <= req_line;
            if (state_q == RX_LISTEN && !two_phase && seen_q)
                ack_q <= 1'b1;
            else if (add_en)
                ack_q <= seen_q;
        end
    end

    assign ack_line = ack_q;
    assign fwd_seen = seen_q;

endmodule

// File: rtl/burst_link_dlv.sv
module burst_link_dlv
    import burst_link_pkg::*;
#(
    parameter int TXC_W = 4,
    parameter int RXC_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             add_en,
    input  logic [TXC_W-1:0] add_val,
    input  logic             release_evt,
    output logic             new_evt,
    output logic [RXC_W-1:0] backlog_cnt
);

    localparam int SUM_W = RXC_W + 1;

    dlv_state_e       state_q, state_d;
    logic [RXC_W-1:0] back_q, back_d;
    logic [SUM_W-1:0] sum_w, add_w;
    logic             take;

    assign take  = (state_q == DLV_EMPTY) && (back_q != '0);
    assign add_w = add_en ? SUM_W'(add_val) : '0;

    always_comb begin
        sum_w = SUM_W'(back_q) + add_w - SUM_W'(take);
        back_d = sum_w[SUM_W-1] ? '1 : sum_w[RXC_W-1:0];
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DLV_EMPTY: if (take) state_d = DLV_OFFER;
            DLV_OFFER: if (release_evt) state_d = DLV_EMPTY;
            default:   state_d = DLV_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= DLV_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) back_q <= '0;
        else        back_q <= back_d;
    end

    assign new_evt     = (state_q == DLV_OFFER);
    assign backlog_cnt = back_q;

endmodule

// File: rtl/burst_link.sv
module burst_link #(
    parameter int TXC_W = 4,
    parameter int RXC_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             two_phase,
    input  logic             load_evt,
    input  logic             strobe_fwd,
    input  logic             strobe_back,
    input  logic             release_evt,
    output logic             new_evt,
    output logic [TXC_W-1:0] pending_cnt,
    output logic [TXC_W-1:0] burst_bus,
    output logic [RXC_W-1:0] backlog_cnt,
    output logic             req_line,
    output logic             ack_line,
    output logic             tx_busy
);

    logic fwd_seen;
    logic add_en;

    burst_link_tx #(.TXC_W(TXC_W)) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .two_phase   (two_phase),
        .load_evt    (load_evt),
        .strobe_back (strobe_back),
        .ack_line    (ack_line),
        .req_line    (req_line),
        .burst_bus   (burst_bus),
        .pending_cnt (pending_cnt),
        .tx_busy     (tx_busy)
    );

    burst_link_rx u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .two_phase  (two_phase),
        .strobe_fwd (strobe_fwd),
        .req_line   (req_line),
        .ack_line   (ack_line),
        .fwd_seen   (fwd_seen),
        .add_en     (add_en)
    );

    burst_link_dlv #(.TXC_W(TXC_W), .RXC_W(RXC_W)) u_dlv (
        .clk         (clk),
        .rst_n       (rst_n),
        .add_en      (add_en),
        .add_val     (burst_bus),
        .release_evt (release_evt),
        .new_evt     (new_evt),
        .backlog_cnt (backlog_cnt)
    );

endmodule

// File: rtl/burst_link_chk.sv
module burst_link_chk #(
    parameter int TXC_W = 4,
    parameter int RXC_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             two_phase,
    input logic             load_evt,
    input logic             release_evt,
    input logic             new_evt,
    input logic             tx_busy,
    input logic [TXC_W-1:0] pending_cnt,
    input logic [TXC_W-1:0] burst_bus,
    input logic [RXC_W-1:0] backlog_cnt,
    input logic             fwd_seen,
    input logic             add_en
);

    localparam logic [TXC_W-1:0] TX_MAX = '1;
    localparam logic [TXC_W-1:0] TX_ONE = TXC_W'(1);
    localparam logic [RXC_W-1:0] RX_ONE = RXC_W'(1);

    a_r2_first_burst: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy && pending_cnt == '0 && load_evt |=> tx_busy && burst_bus == TX_ONE);

    a_r3_bus_hold: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy |=> $stable(burst_bus));

    a_r4_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy && pending_cnt == TX_MAX |=> pending_cnt == TX_MAX);

    a_r6_late_valid: assert property (@(posedge clk) disable iff (!rst_n)
        add_en && !two_phase |-> !fwd_seen);

    a_r9_offer: assert property (@(posedge clk) disable iff (!rst_n)
        !new_evt && backlog_cnt != '0 && !add_en
        |=> new_evt && backlog_cnt == $past(backlog_cnt) - RX_ONE);

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        new_evt && !release_evt && !add_en |=> new_evt && $stable(backlog_cnt));

    a_r10_drop: assert property (@(posedge clk) disable iff (!rst_n)
        new_evt && release_evt |=> !new_evt);

endmodule

bind burst_link burst_link_chk #(.TXC_W(TXC_W), .RXC_W(RXC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .two_phase   (two_phase),
    .load_evt    (load_evt),
    .release_evt (release_evt),
    .new_evt     (new_evt),
    .tx_busy     (tx_busy),
    .pending_cnt (pending_cnt),
    .burst_bus   (burst_bus),
    .backlog_cnt (backlog_cnt),
    .fwd_seen    (fwd_seen),
    .add_en      (add_en)
);

// File: tb/sim_burst_link.sv
module sim_burst_link;

    localparam int CLK_PERIOD = 10;
    localparam int TXC_W = 4;
    localparam int RXC_W = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             two_phase = 1'b0;
    logic             load_evt = 1'b0;
    logic             strobe_fwd = 1'b0;
    logic             strobe_back = 1'b0;
    logic             release_evt = 1'b0;
    logic             new_evt;
    logic [TXC_W-1:0] pending_cnt;
    logic [TXC_W-1:0] burst_bus;
    logic [RXC_W-1:0] backlog_cnt;
    logic             req_line;
    logic             ack_line;
    logic             tx_busy;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    burst_link #(.TXC_W(TXC_W), .RXC_W(RXC_W)) u0 (
        .clk(clk), .rst_n(rst_n), .two_phase(two_phase), .load_evt(load_evt),
        .strobe_fwd(strobe_fwd), .strobe_back(strobe_back), .release_evt(release_evt),
        .new_evt(new_evt), .pending_cnt(pending_cnt), .burst_bus(burst_bus),
        .backlog_cnt(backlog_cnt), .req_line(req_line), .ack_line(ack_line),
        .tx_busy(tx_busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic mode);
        rst_n = 1'b0;
        two_phase = mode;
        tick(2);
        rst_n = 1'b1;
        tick(1);
    endtask

    task automatic load_n(input int n);
        load_evt = 1'b1;
        tick(n);
        load_evt = 1'b0;
    endtask

    task automatic pulse_fwd();
        strobe_fwd = 1'b1;
        tick(1);
        strobe_fwd = 1'b0;
        tick(3);
    endtask

    task automatic pulse_back();
        strobe_back = 1'b1;
        tick(1);
        strobe_back = 1'b0;
        tick(3);
    endtask

    task automatic drain(output int offers);
        offers = 0;
        while (new_evt && offers < 100) begin
            offers++;
            release_evt = 1'b1;
            tick(1);
            release_evt = 1'b0;
            tick(1);
        end
    endtask

    // R1 reset values
    task automatic t_reset();
        do_reset(1'b0);
        chk("R1 new_evt", new_evt, 0);
        chk("R1 req_line", req_line, 0);
        chk("R1 ack_line", ack_line, 0);
        chk("R1 tx_busy", tx_busy, 0);
        chk("R1 pending_cnt", pending_cnt, 0);
        chk("R1 backlog_cnt", backlog_cnt, 0);
    endtask

    // single event, 4-phase
    task automatic t_single_4p();
        int offers;
        do_reset(1'b0);
        load_n(1);
        chk("R2 bus", burst_bus, 1);
        chk("R2 req rise", req_line, 1);
        chk("R2 busy", tx_busy, 1);
        tick(3);
        chk("R5 ack gated", ack_line, 0);
        pulse_fwd();
        chk("R6 ack up", ack_line, 1);
        chk("R6 no add on rise", backlog_cnt, 0);
        chk("R6 no offer on rise", new_evt, 0);
        pulse_back();
        chk("R6 req fall", req_line, 0);
        pulse_fwd();
        chk("R9 offer", new_evt, 1);
        chk("R9 backlog", backlog_cnt, 0);
        chk("R6 ack down", ack_line, 0);
        chk("R8 busy before return", tx_busy, 1);
        pulse_back();
        chk("R8 idle after return", tx_busy, 0);
        release_evt = 1'b1;
        tick(1);
        release_evt = 1'b0;
        chk("R10 release drops", new_evt, 0);
        tick(2);
        drain(offers);
        chk("R11 single offers", offers, 0);
    endtask

    // four loads, 4-phase: burst of 1 then 3
    task automatic t_burst_4p();
        int offers;
        do_reset(1'b0);
        load_n(4);
        chk("R2 first burst", burst_bus, 1);
        chk("R3 pending", pending_cnt, 3);
        pulse_fwd();
        tick(5);
        chk("R8 still busy", tx_busy, 1);
        chk("R8 still pending", pending_cnt, 3);
        chk("R8 req held", req_line, 1);
        pulse_back();
        pulse_fwd();
        pulse_back();
        chk("R3 second burst", burst_bus, 3);
        chk("R3 pending cleared", pending_cnt, 0);
        chk("R3 req up again", req_line, 1);
        chk("R9 first offered", new_evt, 1);
        pulse_fwd();
        pulse_back();
        pulse_fwd();
        chk("R10 no take while offered", backlog_cnt, 3);
        chk("R10 offer held", new_evt, 1);
        pulse_back();
        drain(offers);
        chk("R11 burst offers", offers, 4);
        chk("R11 backlog empty", backlog_cnt, 0);
    endtask

    // 2-phase, two loads
    task automatic t_two_phase();
        int offers;
        do_reset(1'b1);
        load_n(2);
        chk("R2 2p bus", burst_bus, 1);
        chk("R2 2p req toggled", req_line, 1);
        chk("R3 2p pending", pending_cnt, 1);
        tick(3);
        chk("R5 2p ack gated", ack_line, 0);
        chk("R5 2p no add", backlog_cnt, 0);
        pulse_fwd();
        chk("R7 ack follows", ack_line, 1);
        chk("R7 added and offered", new_evt, 1);
        chk("R8 2p busy", tx_busy, 1);
        chk("R8 2p pending kept", pending_cnt, 1);
        pulse_back();
        chk("R3 2p second burst", burst_bus, 1);
        chk("R3 2p req toggled back", req_line, 0);
        chk("R3 2p pending cleared", pending_cnt, 0);
        pulse_fwd();
        chk("R7 second add", backlog_cnt, 1);
        chk("R7 ack follows low", ack_line, 0);
        pulse_back();
        chk("R8 2p idle", tx_busy, 0);
        drain(offers);
        chk("R11 2p offers", offers, 2);
    endtask

    // saturation of the transmit counter
    task automatic t_saturate();
        int offers;
        do_reset(1'b0);
        load_n(21);
        chk("R4 saturated", pending_cnt, 15);
        pulse_fwd();
        pulse_back();
        pulse_fwd();
        pulse_back();
        chk("R4 burst of max", burst_bus, 15);
        pulse_fwd();
        pulse_back();
        pulse_fwd();
        pulse_back();
        chk("R4 backlog", backlog_cnt, 15);
        drain(offers);
        chk("R4 offers", offers, 16);
    endtask

    initial begin
        tick(1);
        t_reset();
        t_single_4p();
        t_burst_4p();
        t_two_phase();
        t_saturate();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog all requirements actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule